// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the stack-frame work of a subroutine call or return on behalf of a processor core. It has one 32-bit word port to memory, with a request/ready handshake. The core supplies the current stack pointer, frame pointer and program counter. For a call it also supplies the branch target and says whether the call was absolute or through a register. A return needs no operands.

A call first steps the stack pointer down past one reserved static-chain word, which it never writes. It then stores the return address and, below it, the caller's frame pointer. When the call ends, the stack pointer and the frame pointer both point at that saved frame pointer, and the program counter takes the target.

A return does the reverse, starting at the frame pointer. The word there becomes the new frame pointer. The next word up becomes the new program counter. The stack pointer ends just above the reserved slot.

The results appear on three output registers. These change only in the single cycle in which `done` is high. A sequence cut short by reset therefore leaves no half-written frame state behind.

Top module: `frame_sequencer`

## Requirements
- R1: While reset is held, `sp_out`, `fp_out` and `pc_out` read zero, and `busy`, `done` and `mem_req` read low.
- R2: A call issues, as its first memory access, a write of the return address to the word at `sp_in - 8`. The word at `sp_in - 4` is never touched. The return address is `cur_pc + 6` when `call_abs` is 1 and `cur_pc + 2` when it is 0.
- R3: The second access of a call writes `fp_in` to the word at `sp_in - 12`.
- R4: When a call ends, `sp_out` and `fp_out` both equal `sp_in - 12`, and `pc_out` equals `call_target`.
- R5: A return issues exactly two reads and no write: first from the address `fp_in`, then from `fp_in + 4`.
- R6: When a return ends, `fp_out` holds the first word read and `pc_out` holds the second. `sp_out` equals `fp_in + 12`.
- R7: An access is taken only in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R8: `done` is high for exactly one cycle, the cycle after the last access is taken. `sp_out`, `fp_out` and `pc_out` change in no other cycle.
- R9: A request is accepted only while `busy` is low; requests and operand changes while busy have no effect. If `call_req` and `ret_req` are both high, the call is taken.
- R10: Reset in the middle of a sequence returns every output to its R1 value, and no partial result is ever presented.
- R11: Address arithmetic wraps modulo 2^32. For example, a call with `sp_in = 8` writes to the words at 0 and 0xFFFFFFFC.
- R12: On the memory port a word is big-endian: the byte at the lowest address travels on bits 31:24. With the default lane setting, the port word equals the register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a call (sampled while idle) |
| ret_req | input | 1 | Start a return (sampled while idle) |
| call_abs | input | 1 | 1: absolute call (six-byte instruction); 0: call through a register |
| cur_pc | input | 32 | Address of the call instruction |
| call_target | input | 32 | Address the call branches to |
| sp_in | input | 32 | Current stack pointer |
| fp_in | input | 32 | Current frame pointer |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts or completes the access this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| sp_out | output | 32 | Resulting stack pointer |
| fp_out | output | 32 | Resulting frame pointer |
| pc_out | output | 32 | Resulting program counter |

## Verification
The assertions assume the memory side obeys the handshake. It supplies `mem_rdata` in the cycle it raises `mem_ready`, and it may hold `mem_ready` low for any number of cycles. The assertions also assume reset starts low at time zero.

The stimulus drives every input half a period away from the active edge. It keeps `mem_ready` either always high or following a fixed stall pattern. It deliberately raises both request lines with junk operands during busy cycles, to show they are ignored. No check depends on any cycle count other than the handshake order.

// File: rtl/frame_seq_pkg.sv
`timescale 1ns/1ps
package frame_seq_pkg;

    localparam int FS_WORD_W = 32;

    typedef logic [FS_WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        FS_IDLE    = 3'd0,
        FS_PUSH_RA = 3'd1,
        FS_PUSH_FP = 3'd2,
        FS_POP_FP  = 3'd3,
        FS_POP_PC  = 3'd4
    } fs_state_e;

    // Every register of the sequencer, next and current value share this type.
    typedef struct packed {
        fs_state_e state;
        word_t     base;      // stack pointer (call) or frame pointer (return) at start
        word_t     save_fp;   // caller frame pointer to be pushed
        word_t     ret_addr;  // return address to be pushed
        word_t     target;    // branch target of the call
        word_t     got_fp;    // frame pointer popped by a return
        word_t     out_sp;
        word_t     out_fp;
        word_t     out_pc;
        logic      done;
    } fs_regs_t;

endpackage

// File: rtl/fs_lane_order.sv
`timescale 1ns/1ps
module fs_lane_order #(
    parameter int BYTES   = 4,
    parameter bit REVERSE = 1'b0
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);

    generate
        if (REVERSE) begin : g_rev
            for (genvar i = 0; i < BYTES; i++) begin : g_lane
                assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
            end
        end else begin : g_keep
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/fs_engine.sv
`timescale 1ns/1ps
module fs_engine
    import frame_seq_pkg::*;
#(
    parameter int CHAIN_SLOTS = 1,
    parameter int RA_SHORT    = 2,
    parameter int RA_LONG     = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  call_req,
    input  logic  ret_req,
    input  logic  call_abs,
    input  word_t cur_pc,
    input  word_t call_target,
    input  word_t sp_in,
    input  word_t fp_in,
    input  word_t mem_rword,
    input  logic  mem_ready,
    output logic  mem_req,
    output logic  mem_we,
    output word_t mem_addr,
    output word_t mem_wword,
    output logic  busy,
    output logic  done,
    output word_t sp_out,
    output word_t fp_out,
    output word_t pc_out
);

    localparam int    STEP     = FS_WORD_W / 8;
    localparam word_t OFS_RA   = word_t'((CHAIN_SLOTS + 1) * STEP);
    localparam word_t OFS_FP   = word_t'((CHAIN_SLOTS + 2) * STEP);
    localparam word_t OFS_PC   = word_t'(STEP);
    localparam word_t POP_SKIP = word_t'((CHAIN_SLOTS + 2) * STEP);
    localparam word_t RA_S     = word_t'(RA_SHORT);
    localparam word_t RA_L     = word_t'(RA_LONG);

    fs_regs_t q, d;

    // Next-state logic: every register value computed here.
    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            FS_IDLE: begin
                if (call_req) begin
                    d.state    = FS_PUSH_RA;
                    d.base     = sp_in;
                    d.save_fp  = fp_in;
                    d.ret_addr = cur_pc + (call_abs ? RA_L : RA_S);
                    d.target   = call_target;
                end else if (ret_req) begin
                    d.state = FS_POP_FP;
                    d.base  = fp_in;
                end
            end
            FS_PUSH_RA: begin
                if (mem_ready) d.state = FS_PUSH_FP;
            end
            FS_PUSH_FP: begin
                if (mem_ready) begin
                    d.state  = FS_IDLE;
                    d.out_sp = q.base - OFS_FP;
                    d.out_fp = q.base - OFS_FP;
                    d.out_pc = q.target;
                    d.done   = 1'b1;
                end
            end
            FS_POP_FP: begin
                if (mem_ready) begin
                    d.state  = FS_POP_PC;
                    d.got_fp = mem_rword;
                end
            end
            FS_POP_PC: begin
                if (mem_ready) begin
                    d.state  = FS_IDLE;
                    d.out_fp = q.got_fp;
                    d.out_pc = mem_rword;
                    d.out_sp = q.base + POP_SKIP;
                    d.done   = 1'b1;
                end
            end
            default: d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Memory port, decoded from the current state only.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wword = '0;
        unique case (q.state)
            FS_PUSH_RA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base - OFS_RA;
                mem_wword = q.ret_addr;
            end
            FS_PUSH_FP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base - OFS_FP;
                mem_wword = q.save_fp;
            end
            FS_POP_FP: begin
                mem_req  = 1'b1;
                mem_addr = q.base;
            end
            FS_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = q.base + OFS_PC;
            end
            default: ;
        endcase
    end

    assign busy   = (q.state != FS_IDLE);
    assign done   = q.done;
    assign sp_out = q.out_sp;
    assign fp_out = q.out_fp;
    assign pc_out = q.out_pc;

endmodule

// File: rtl/frame_sequencer.sv
`timescale 1ns/1ps
module frame_sequencer #(
    parameter int CHAIN_SLOTS  = 1,
    parameter int RA_SHORT     = 2,
    parameter int RA_LONG      = 6,
    parameter bit LANE_REVERSE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        call_req,
    input  logic        ret_req,
    input  logic        call_abs,
    input  logic [31:0] cur_pc,
    input  logic [31:0] call_target,
    input  logic [31:0] sp_in,
    input  logic [31:0] fp_in,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        busy,
    output logic        done,
    output logic [31:0] sp_out,
    output logic [31:0] fp_out,
    output logic [31:0] pc_out
);

    import frame_seq_pkg::*;

    localparam int BYTES = FS_WORD_W / 8;

    word_t rword_native;
    word_t wword_native;

    fs_lane_order #(.BYTES(BYTES), .REVERSE(LANE_REVERSE)) u_rd_lanes (
        .din  (mem_rdata),
        .dout (rword_native)
    );

    fs_lane_order #(.BYTES(BYTES), .REVERSE(LANE_REVERSE)) u_wr_lanes (
        .din  (wword_native),
        .dout (mem_wdata)
    );

    fs_engine #(
        .CHAIN_SLOTS (CHAIN_SLOTS),
        .RA_SHORT    (RA_SHORT),
        .RA_LONG     (RA_LONG)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .call_abs    (call_abs),
        .cur_pc      (cur_pc),
        .call_target (call_target),
        .sp_in       (sp_in),
        .fp_in       (fp_in),
        .mem_rword   (rword_native),
        .mem_ready   (mem_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wword   (wword_native),
        .busy        (busy),
        .done        (done),
        .sp_out      (sp_out),
        .fp_out      (fp_out),
        .pc_out      (pc_out)
    );

endmodule

// File: rtl/frame_sequencer_chk.sv
`timescale 1ns/1ps
module frame_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        busy,
    input logic        done,
    input logic [31:0] sp_out,
    input logic [31:0] fp_out,
    input logic [31:0] pc_out
);

    // R7: a stalled access keeps its request and its payload.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R8: done never lasts two cycles.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: result registers move only together with done.
    p_outs_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sp_out) && $stable(fp_out) && $stable(pc_out)));

    // R8: the done cycle is already idle, ready for the next request.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: no memory traffic outside a sequence.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind frame_sequencer frame_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .sp_out    (sp_out),
    .fp_out    (fp_out),
    .pc_out    (pc_out)
);

// File: tb/frame_sequencer_tb_top.sv
`timescale 1ns/1ps
module frame_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        call_req, ret_req, call_abs;
    logic [31:0] cur_pc, call_target, sp_in, fp_in;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done;
    logic [31:0] sp_out, fp_out, pc_out;

    always #5 clk = ~clk;

    frame_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .call_abs(call_abs), .cur_pc(cur_pc), .call_target(call_target),
        .sp_in(sp_in), .fp_in(fp_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done),
        .sp_out(sp_out), .fp_out(fp_out), .pc_out(pc_out)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // ---------------- reference model state ----------------
    typedef struct {
        logic [31:0] addr;
        bit          we;
        logic [31:0] wd;
        int          kind;   // 2: first call write, 3: second call write, 5: return read
    } acc_t;

    typedef struct {
        int          typ;    // 0 call, 1 return, 2 both requests raised
        bit          abs_call;
        logic [31:0] pc, tgt, sp, fp;
        bit          inject;
        int          rmode;  // 0 ready always, 1 stall pattern
    } op_t;

    bit [31:0] mem [bit [31:0]];
    acc_t      accq [$];
    op_t       ops [6];
    string     op_note [6];

    bit          m_busy = 0, exp_done = 0, cur_ret = 0, cur_inject = 0;
    logic [31:0] m_sp = 0, m_fp = 0, m_pc = 0;
    logic [31:0] cur_S, cur_F, cur_T, rd0;
    int          rd_cnt, rmode = 0, cyc = 0, next_op = 0, cur_op = 0;
    bit          hold_pend = 0;
    logic [31:0] hold_addr;

    function automatic logic [31:0] memrd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'hC0DE_0000;
    endfunction

    function automatic string kind_tag(int k);
        case (k)
            2:       return "R2 return-address push";
            3:       return "R3 frame-pointer push";
            default: return "R5 return read";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic start_op(int n);
        op_t o = ops[n];
        cur_op     = n;
        cur_inject = o.inject;
        rmode      = o.rmode;
        call_abs   = o.abs_call;
        cur_pc     = o.pc;
        call_target = o.tgt;
        sp_in      = o.sp;
        fp_in      = o.fp;
        call_req   = (o.typ == 0 || o.typ == 2);
        ret_req    = (o.typ == 1 || o.typ == 2);
        m_busy     = 1;
        rd_cnt     = 0;
        cur_S = o.sp; cur_F = o.fp; cur_T = o.tgt;
        if (o.typ == 1) begin
            cur_ret = 1;
            accq.push_back('{o.fp, 1'b0, 32'h0, 5});
            accq.push_back('{o.fp + 32'd4, 1'b0, 32'h0, 5});
        end else begin
            // R9: with both requests raised the call wins.
            cur_ret = 0;
            accq.push_back('{o.sp - 32'd8, 1'b1, o.pc + (o.abs_call ? 32'd6 : 32'd2), 2});
            accq.push_back('{o.sp - 32'd12, 1'b1, o.fp, 3});
        end
    endtask

    task automatic do_cycle();
        bit busy_now;
        @(negedge clk);
        cyc++;
        busy_now = m_busy;
        chk(done === exp_done, "R8 done pulse", {31'd0, done}, {31'd0, exp_done});
        exp_done = 0;
        chk(busy === busy_now, "R9 busy", {31'd0, busy}, {31'd0, busy_now});
        chk(sp_out === m_sp, "R4 or R6 (R8 hold) sp_out", sp_out, m_sp);
        chk(fp_out === m_fp, "R4 or R6 (R8 hold) fp_out", fp_out, m_fp);
        chk(pc_out === m_pc, "R4 or R6 (R8 hold) pc_out", pc_out, m_pc);
        if (hold_pend) begin
            chk(mem_req === 1'b1 && mem_addr === hold_addr, "R7 stalled access held",
                mem_addr, hold_addr);
            hold_pend = 0;
        end
        case (rmode)
            0:       mem_ready = 1'b1;
            1:       mem_ready = (cyc % 3 == 2);
            default: mem_ready = 1'b0;
        endcase
        mem_rdata = memrd(mem_addr);  // R12: port word is the register value
        if (mem_req === 1'b1) begin
            if (accq.size() == 0) begin
                chk(1'b0, "R9 unexpected memory request", mem_addr, 32'h0);
            end else if (!mem_ready) begin
                hold_pend = 1;
                hold_addr = mem_addr;
            end else begin
                acc_t a = accq.pop_front();
                string t = {kind_tag(a.kind), " ", op_note[cur_op]};
                chk(mem_addr === a.addr, t, mem_addr, a.addr);
                chk(mem_we === a.we, t, {31'd0, mem_we}, {31'd0, a.we});
                if (a.we) begin
                    chk(mem_wdata === a.wd, t, mem_wdata, a.wd);
                    mem[a.addr] = mem_wdata;
                end else begin
                    if (rd_cnt == 0) rd0 = mem_rdata;
                    rd_cnt++;
                end
                if (accq.size() == 0) begin
                    if (cur_ret) begin
                        m_fp = rd0; m_pc = mem_rdata; m_sp = cur_F + 32'd12;   // R6
                    end else begin
                        m_sp = cur_S - 32'd12; m_fp = cur_S - 32'd12; m_pc = cur_T; // R4
                    end
                    exp_done = 1;
                    m_busy   = 0;
                end
            end
        end
        if (!busy_now && next_op < 6) begin
            start_op(next_op);
            next_op++;
        end else if (busy_now && cur_inject) begin
            // R9: junk requests while busy must change nothing.
            call_req = 1; ret_req = 1; call_abs = ~call_abs;
            cur_pc = 32'hDEAD_0000 + cyc; call_target = 32'hBAD0_0000;
            sp_in = 32'h5555_0000; fp_in = 32'hAAAA_0000;
        end else begin
            call_req = 0; ret_req = 0;
        end
    endtask

    initial begin
        ops[0] = '{0, 1'b1, 32'h0000_0100, 32'h0000_2000, 32'h0000_8000, 32'h0000_7000, 1'b0, 0};
        op_note[0] = "absolute call";
        ops[1] = '{1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0000_7FF4, 1'b0, 0};
        op_note[1] = "return of that call";
        ops[2] = '{0, 1'b0, 32'h0000_03FE, 32'h0000_0010, 32'h0000_0008, 32'h0000_0044, 1'b1, 1};
        op_note[2] = "register call R11 wrap";
        ops[3] = '{2, 1'b1, 32'h0000_0A00, 32'h0000_3000, 32'h0000_1000, 32'h0000_0F00, 1'b0, 0};
        op_note[3] = "R9 call priority";
        ops[4] = '{1, 1'b0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF8, 1'b1, 1};
        op_note[4] = "return R11 wrap";
        ops[5] = '{1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0000_0500, 1'b0, 1};
        op_note[5] = "return unwritten frame";

        rst_n = 0; call_req = 0; ret_req = 0; call_abs = 0;
        cur_pc = 0; call_target = 0; sp_in = 0; fp_in = 0;
        mem_ready = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sp_out === 0 && fp_out === 0 && pc_out === 0, "R1 reset outputs", sp_out | fp_out | pc_out, 32'h0);
        chk(busy === 0 && done === 0 && mem_req === 0, "R1 reset controls",
            {29'd0, busy, done, mem_req}, 32'h0);
        rst_n = 1;

        for (int i = 0; i < 400; i++) begin
            do_cycle();
            if (next_op == 6 && !m_busy && !exp_done) break;
        end
        chk(next_op == 6 && !m_busy, "R8 all sequences completed", next_op, 6);
        repeat (2) do_cycle();

        // R10: reset aborts a stalled call
        @(negedge clk);
        rmode = 2; mem_ready = 0;
        call_req = 1; call_abs = 1; cur_pc = 32'h40; call_target = 32'h80;
        sp_in = 32'h9000; fp_in = 32'h8800;
        @(negedge clk);
        call_req = 0;
        chk(busy === 1'b1, "R10 sequence started before abort", {31'd0, busy}, 32'h1);
        repeat (2) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(sp_out === 0 && fp_out === 0 && pc_out === 0, "R10 no partial result",
            sp_out | fp_out | pc_out, 32'h0);
        chk(busy === 0 && done === 0 && mem_req === 0, "R10 controls after abort",
            {29'd0, busy, done, mem_req}, 32'h0);
        rst_n = 1;
        m_sp = 0; m_fp = 0; m_pc = 0; m_busy = 0; exp_done = 0; hold_pend = 0;
        accq.delete();
        rmode = 0;
        repeat (3) do_cycle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule